// File: doc/BRIEF.md
# Character-Grid Display Host Register Interface

This block is the processor-facing side of a character-grid display controller. A host talks to it over a byte-wide bus with two select lines: one chooses command or data mode, the other chooses register A or register B. Commands take two steps. The host first writes an operand into A, then writes an opcode into B. The opcode acts on the operand held in A. It can place the text cursor, load the mode byte, load the control byte, or load the display origin row.

In data mode, each byte written to B is handled according to the top three bits of the mode byte. One mode writes the byte into a 1024-byte display RAM at the cursor position and advances the cursor. A second mode only advances the cursor. Every other mode does nothing.

The RAM is external. The block drives its write port and always presents the 10-bit RAM address of the cursor. This address is folded: rows 12 to 15 and columns 32 and above map into the top of the memory. A busy flag can be read in bit 7 of the status byte. The flag is high for one cycle after each B-register action.

Top module: `txtdisp_host_if`

## Requirements
- R1: Reset (asynchronous, active low) clears X, Y, origin, control, mode, A, B, busy and the RAM write strobe. After reset, every read that does not return 0xFF returns 0x00.
- R2: Writing register A (sel_b=0), in either mode, only stores the byte in A. The cursor, mode, control and origin keep their values.
- R3: A command write to B (sel_cmd=1, sel_b=1) decodes wr_data[7:5] as follows: 000 sets X=0 and Y=A[4:0]; 001 sets Y=A[4:0]; 010 sets X=A[5:0]; 011 advances the cursor. The new cursor appears at the ports in the cycle after the write.
- R4: A cursor advance adds 1 to X. When the result is 40, X becomes 0 and Y becomes (Y+1) mod 24 in the same step. From X=63, X wraps to 0 in its 6 bits and Y is unchanged.
- R5: Command opcode 100 loads the mode byte from A. Opcode 101 loads the control byte from A. Opcode 110 loads the origin from A[5:0]. Opcode 111 changes nothing.
- R6: cur_addr is built as follows. If Y[3:2]=11, it is {2'b11, X[5:3], 2'b11, X[2:0]}. Otherwise, if X[5]=1, it is {2'b11, Y[2:0], Y[4:3], X[2:0]}. Otherwise it is {Y[4:0], X[4:0]}.
- R7: A data write to B (sel_cmd=0, sel_b=1) with mode[7:5]=000 raises mem_we for the next cycle. During that cycle mem_addr is the cursor address from before the write and mem_wdata is the written byte. The cursor advances as in R4.
- R8: A data write to B with mode[7:5]=001 advances the cursor and does not raise mem_we. With any other mode value it changes neither the cursor nor mem_we. B still stores the byte in every mode.
- R9: busy is set in the cycle after any write to B or any data-mode read of B. It falls one cycle later unless another such access occurs. A command-mode read of A returns busy in bit 7 with bits 6:0 zero.
- R10: A data-mode read of A returns A. A data-mode read of B returns B. A command-mode read of B returns 0xFF. rd_data is 0x00 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe |
| sel_cmd | input | 1 | 1 = command mode, 0 = data mode |
| sel_b | input | 1 | 1 = register B, 0 = register A |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte (combinational) |
| busy | output | 1 | Busy flag |
| cur_x | output | 6 | Cursor column |
| cur_y | output | 5 | Cursor row |
| cur_addr | output | 10 | RAM address of the cursor |
| mode_reg | output | 8 | Mode byte |
| ctrl_reg | output | 8 | Control byte |
| origin_row | output | 6 | Display origin row |
| mem_we | output | 1 | Display RAM write strobe |
| mem_addr | output | 10 | Display RAM write address |
| mem_wdata | output | 8 | Display RAM write data |

## Verification
The assertions check several properties on every cycle. Writes to A never move the cursor or the mode. An advance from column 39 always returns X to 0. The folded rows always map into the top address block. Every RAM write strobe traces back to a data write made in write mode and carries that write's byte. Busy rises after each B write and drops when no B access follows. Only the bench scenarios can show the exact opcode decode, the mod-24 row wrap, the precise folded addresses, the two non-writing data modes, and the values returned by each register read.

// File: rtl/txtdisp_pkg.sv
package txtdisp_pkg;

  // opcode carried in wr_data[7:5] of a command write to B
  typedef enum logic [2:0] {
    OP_ROW  = 3'd0,
    OP_LDY  = 3'd1,
    OP_LDX  = 3'd2,
    OP_INC  = 3'd3,
    OP_LDM  = 3'd4,
    OP_LDR  = 3'd5,
    OP_LDY0 = 3'd6,
    OP_NOP  = 3'd7
  } cmd_op_e;

  // cursor action selected by the decoder
  typedef enum logic [2:0] {
    CUR_HOLD,
    CUR_ROW,
    CUR_LDY,
    CUR_LDX,
    CUR_INC
  } cur_act_e;

  // data-mode write behaviours from mode[7:5]
  localparam logic [2:0] DMODE_WRITE = 3'd0;
  localparam logic [2:0] DMODE_SKIP  = 3'd1;

endpackage

// File: rtl/txtdisp_addr_map.sv
module txtdisp_addr_map #(
  parameter int XW = 6,
  parameter int YW = 5,
  parameter int AW = 10
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic [AW-1:0] addr
);

  // folded regions: rows 12..15 and columns 32..63
  always_comb begin
    if (y[3:2] == 2'b11) begin
      addr = {2'b11, x[5:3], 2'b11, x[2:0]};
    end else if (x[5]) begin
      addr = {2'b11, y[2:0], y[4:3], x[2:0]};
    end else begin
      addr = {y[4:0], x[4:0]};
    end
  end

endmodule

// File: rtl/txtdisp_cursor.sv
module txtdisp_cursor
  import txtdisp_pkg::*;
#(
  parameter int XW   = 6,
  parameter int YW   = 5,
  parameter int COLS = 40,
  parameter int ROWS = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cur_act_e      act,
  input  logic [XW-1:0] ld_val,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);

  localparam logic [XW-1:0] LAST_COL = XW'(COLS - 1);
  localparam logic [YW:0]   ROWS_W   = (YW+1)'(ROWS);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic [YW:0]   y_sum;
  logic [YW-1:0] y_wrap;
  logic          cur_en;

  // row advance modulo ROWS
  always_comb begin
    y_sum  = {1'b0, y_q} + 1'b1;
    y_wrap = (y_sum >= ROWS_W) ? YW'(y_sum - ROWS_W) : y_sum[YW-1:0];
  end

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    cur_en = 1'b1;
    case (act)
      CUR_ROW: begin
        x_d = '0;
        y_d = ld_val[YW-1:0];
      end
      CUR_LDY: y_d = ld_val[YW-1:0];
      CUR_LDX: x_d = ld_val;
      CUR_INC: begin
        if (x_q == LAST_COL) begin
          x_d = '0;
          y_d = y_wrap;
        end else begin
          x_d = x_q + 1'b1;
        end
      end
      default: cur_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (cur_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x = x_q;
  assign y = y_q;

endmodule

// File: rtl/txtdisp_busy_ctl.sv
module txtdisp_busy_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic busy
);

  logic busy_q, busy_d;

  // high for the cycle after each B access, then drops
  always_comb busy_d = set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

endmodule

// File: rtl/txtdisp_host_if.sv
module txtdisp_host_if
  import txtdisp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int XW   = 6,
  parameter int YW   = 5,
  parameter int AW   = 10,
  parameter int COLS = 40,
  parameter int ROWS = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          sel_cmd,
  input  logic          sel_b,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] mode_reg,
  output logic [DW-1:0] ctrl_reg,
  output logic [XW-1:0] origin_row,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam int OPW = 3;

  logic [DW-1:0] reg_a_q, reg_b_q, mode_q, ctrl_q;
  logic [XW-1:0] origin_q;
  logic          mem_we_q;
  logic [AW-1:0] mem_addr_q;
  logic [DW-1:0] mem_wdata_q;

  logic       wr_a, wr_b, cmd_b, dat_b, rd_dat_b;
  cmd_op_e    op;
  logic [2:0] dmode;
  cur_act_e   cur_act;
  logic       mode_en, ctrl_en, origin_en;
  logic       mem_we_d;

  // access decode
  always_comb begin
    wr_a     = wr_en & ~sel_b;
    wr_b     = wr_en & sel_b;
    cmd_b    = wr_b & sel_cmd;
    dat_b    = wr_b & ~sel_cmd;
    rd_dat_b = rd_en & sel_b & ~sel_cmd;
    op       = cmd_op_e'(wr_data[DW-1 -: OPW]);
    dmode    = mode_q[DW-1 -: OPW];
  end

  // opcode and data-mode decode
  always_comb begin
    cur_act   = CUR_HOLD;
    mode_en   = 1'b0;
    ctrl_en   = 1'b0;
    origin_en = 1'b0;
    mem_we_d  = 1'b0;
    if (cmd_b) begin
      case (op)
        OP_ROW:  cur_act   = CUR_ROW;
        OP_LDY:  cur_act   = CUR_LDY;
        OP_LDX:  cur_act   = CUR_LDX;
        OP_INC:  cur_act   = CUR_INC;
        OP_LDM:  mode_en   = 1'b1;
        OP_LDR:  ctrl_en   = 1'b1;
        OP_LDY0: origin_en = 1'b1;
        default: cur_act   = CUR_HOLD;
      endcase
    end else if (dat_b) begin
      if (dmode == DMODE_WRITE) begin
        cur_act  = CUR_INC;
        mem_we_d = 1'b1;
      end else if (dmode == DMODE_SKIP) begin
        cur_act  = CUR_INC;
      end
    end
  end

  txtdisp_cursor #(
    .XW(XW), .YW(YW), .COLS(COLS), .ROWS(ROWS)
  ) u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (cur_act),
    .ld_val (reg_a_q[XW-1:0]),
    .x      (cur_x),
    .y      (cur_y)
  );

  txtdisp_addr_map #(
    .XW(XW), .YW(YW), .AW(AW)
  ) u_addr_map (
    .x    (cur_x),
    .y    (cur_y),
    .addr (cur_addr)
  );

  txtdisp_busy_ctl u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (wr_b | rd_dat_b),
    .busy    (busy)
  );

  // register file with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a_q  <= '0;
      reg_b_q  <= '0;
      mode_q   <= '0;
      ctrl_q   <= '0;
      origin_q <= '0;
    end else begin
      if (wr_a)      reg_a_q  <= wr_data;
      if (wr_b)      reg_b_q  <= wr_data;
      if (mode_en)   mode_q   <= reg_a_q;
      if (ctrl_en)   ctrl_q   <= reg_a_q;
      if (origin_en) origin_q <= reg_a_q[XW-1:0];
    end
  end

  // registered display RAM write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_we_q <= mem_we_d;
      if (mem_we_d) begin
        mem_addr_q  <= cur_addr;
        mem_wdata_q <= wr_data;
      end
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case ({sel_cmd, sel_b})
        2'b10:   rd_data = {busy, {(DW-1){1'b0}}};
        2'b00:   rd_data = reg_a_q;
        2'b01:   rd_data = reg_b_q;
        default: rd_data = '1;
      endcase
    end
  end

  assign mode_reg   = mode_q;
  assign ctrl_reg   = ctrl_q;
  assign origin_row = origin_q;
  assign mem_we     = mem_we_q;
  assign mem_addr   = mem_addr_q;
  assign mem_wdata  = mem_wdata_q;

endmodule

// File: rtl/txtdisp_host_if_chk.sv
module txtdisp_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       sel_cmd,
  input logic       sel_b,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic [5:0] cur_x,
  input logic [4:0] cur_y,
  input logic [9:0] cur_addr,
  input logic [7:0] mode_reg,
  input logic       mem_we,
  input logic [7:0] mem_wdata
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy && !mem_we && cur_x == 6'd0 && cur_y == 5'd0 && mode_reg == 8'd0));

  // R2
  a_write_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_b) |=> (cur_x == $past(cur_x) && cur_y == $past(cur_y) &&
                           mode_reg == $past(mode_reg)));

  // R4
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_cmd && sel_b && wr_data[7:5] == 3'b011 && cur_x == 6'd39) |=> (cur_x == 6'd0));

  // R6
  fold_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_y[3:2] == 2'b11) |-> ((cur_addr & 10'h318) == 10'h318));

  // R7
  mem_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_en && !sel_cmd && sel_b && mode_reg[7:5] == 3'b000));

  // R7
  mem_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(wr_data)));

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_b) |=> busy);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && sel_b) && !(rd_en && sel_b && !sel_cmd)) |=> !busy);

endmodule

bind txtdisp_host_if txtdisp_host_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .sel_cmd   (sel_cmd),
  .sel_b     (sel_b),
  .wr_data   (wr_data),
  .busy      (busy),
  .cur_x     (cur_x),
  .cur_y     (cur_y),
  .cur_addr  (cur_addr),
  .mode_reg  (mode_reg),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata)
);

// File: tb/txtdisp_host_if_bench.sv
`timescale 1ns/1ps
module txtdisp_host_if_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0, rd_en = 1'b0, sel_cmd = 1'b0, sel_b = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy;
  logic [5:0] cur_x;
  logic [4:0] cur_y;
  logic [9:0] cur_addr;
  logic [7:0] mode_reg, ctrl_reg;
  logic [5:0] origin_row;
  logic       mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  txtdisp_host_if u_txtdisp_host_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .sel_cmd(sel_cmd), .sel_b(sel_b), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .cur_x(cur_x), .cur_y(cur_y), .cur_addr(cur_addr),
    .mode_reg(mode_reg), .ctrl_reg(ctrl_reg), .origin_row(origin_row),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // {sel_cmd, sel_b, data[7:0], exp_x[5:0], exp_y[4:0]}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h05, 6'd0,  5'd0},   // R2 operand only
    {1'b1, 1'b1, 8'h00, 6'd0,  5'd5},   // R3 begin row
    {1'b1, 1'b0, 8'h27, 6'd0,  5'd5},   // R2
    {1'b1, 1'b1, 8'h40, 6'd39, 5'd5},   // R3 load X
    {1'b1, 1'b1, 8'h60, 6'd0,  5'd6},   // R4 wrap at 40
    {1'b1, 1'b0, 8'h1F, 6'd0,  5'd6},   // R2
    {1'b1, 1'b1, 8'h20, 6'd0,  5'd31},  // R3 load Y
    {1'b1, 1'b0, 8'h27, 6'd0,  5'd31},  // R2
    {1'b1, 1'b1, 8'h40, 6'd39, 5'd31},  // R3
    {1'b1, 1'b1, 8'h60, 6'd0,  5'd8},   // R4 (31+1) mod 24
    {1'b0, 1'b0, 8'h33, 6'd0,  5'd8},   // R2 data-mode A
    {1'b0, 1'b1, 8'h41, 6'd1,  5'd8},   // R7 write mode advance
    {1'b1, 1'b0, 8'h3E, 6'd1,  5'd8},   // R2
    {1'b1, 1'b1, 8'h40, 6'd62, 5'd8},   // R3
    {1'b1, 1'b1, 8'h60, 6'd63, 5'd8},   // R4
    {1'b1, 1'b1, 8'h60, 6'd0,  5'd8}    // R4 6-bit wrap, Y kept
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic c, input logic b, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel_cmd = c; sel_b = b; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic c, input logic b, output logic [7:0] d);
    rd_en = 1'b1; sel_cmd = c; sel_b = b;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_xy(input logic [7:0] x, input logic [7:0] y);
    wr(1'b1, 1'b0, y); wr(1'b1, 1'b1, 8'h20);
    wr(1'b1, 1'b0, x); wr(1'b1, 1'b1, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 x", 16'(cur_x), 16'd0);
    chk("R1 y", 16'(cur_y), 16'd0);
    chk("R1 mode", 16'(mode_reg), 16'd0);
    chk("R1 ctrl", 16'(ctrl_reg), 16'd0);
    chk("R1 origin", 16'(origin_row), 16'd0);
    chk("R1 busy", 16'(busy), 16'd0);
    chk("R1 mem_we", 16'(mem_we), 16'd0);
    rd(1'b1, 1'b0, rv); chk("R1 status", 16'(rv), 16'h00);
    rd(1'b0, 1'b0, rv); chk("R1 A", 16'(rv), 16'h00);
    rd(1'b0, 1'b1, rv); chk("R1 B", 16'(rv), 16'h00);
    @(negedge clk);

    // vector walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][20], VEC[i][19], VEC[i][18:11]);
      chk($sformatf("R3/R4 table x %0d", i), 16'(cur_x), 16'(VEC[i][10:5]));
      chk($sformatf("R3/R4 table y %0d", i), 16'(cur_y), 16'(VEC[i][4:0]));
    end

    // R6 address map
    set_xy(8'd45, 8'd12);   chk("R6 folded row", 16'(cur_addr), 16'h3BD);
    set_xy(8'h25, 8'h1A);   chk("R6 folded col", 16'(cur_addr), 16'h35D);
    set_xy(8'h1F, 8'h13);   chk("R6 linear", 16'(cur_addr), 16'h27F);
    set_xy(8'd5, 8'd31);    chk("R6 row 31", 16'(cur_addr), 16'h31D);

    // R7 RAM write
    set_xy(8'd2, 8'd3);
    wr(1'b0, 1'b1, 8'hA5);
    chk("R7 we", 16'(mem_we), 16'd1);
    chk("R7 addr", 16'(mem_addr), 16'h062);
    chk("R7 data", 16'(mem_wdata), 16'hA5);
    chk("R7 x", 16'(cur_x), 16'd3);
    @(negedge clk);
    chk("R7 we drop", 16'(mem_we), 16'd0);

    // R8 and R5 mode load
    wr(1'b1, 1'b0, 8'h20); wr(1'b1, 1'b1, 8'h80);
    chk("R5 mode", 16'(mode_reg), 16'h20);
    wr(1'b0, 1'b1, 8'h11);
    chk("R8 skip we", 16'(mem_we), 16'd0);
    chk("R8 skip x", 16'(cur_x), 16'd4);
    wr(1'b1, 1'b0, 8'h40); wr(1'b1, 1'b1, 8'h80);
    wr(1'b0, 1'b1, 8'h77);
    chk("R8 idle we", 16'(mem_we), 16'd0);
    chk("R8 idle x", 16'(cur_x), 16'd4);
    chk("R8 idle y", 16'(cur_y), 16'd3);
    rd(1'b0, 1'b1, rv); chk("R10 read B", 16'(rv), 16'h77);

    // R5 control, origin, no-op
    wr(1'b1, 1'b0, 8'hFF); wr(1'b1, 1'b1, 8'hA0);
    chk("R5 ctrl", 16'(ctrl_reg), 16'hFF);
    wr(1'b1, 1'b1, 8'hC0);
    chk("R5 origin", 16'(origin_row), 16'h3F);
    wr(1'b1, 1'b0, 8'h12); wr(1'b1, 1'b1, 8'hE0);
    chk("R5 nop ctrl", 16'(ctrl_reg), 16'hFF);
    chk("R5 nop origin", 16'(origin_row), 16'h3F);
    chk("R5 nop mode", 16'(mode_reg), 16'h40);
    chk("R5 nop x", 16'(cur_x), 16'd4);

    // R9 busy
    @(negedge clk);
    wr(1'b1, 1'b1, 8'h60);
    chk("R9 busy set", 16'(busy), 16'd1);
    rd(1'b1, 1'b0, rv); chk("R9 status busy", 16'(rv), 16'h80);
    chk("R9 busy drop", 16'(busy), 16'd0);
    rd(1'b0, 1'b1, rv);
    chk("R9 busy on read B", 16'(busy), 16'd1);
    @(negedge clk);
    chk("R9 busy clear", 16'(busy), 16'd0);
    rd(1'b1, 1'b0, rv); chk("R9 status idle", 16'(rv), 16'h00);

    // R10 reads
    wr(1'b0, 1'b0, 8'h5A);
    rd(1'b0, 1'b0, rv); chk("R10 read A", 16'(rv), 16'h5A);
    rd(1'b1, 1'b1, rv); chk("R10 cmd B", 16'(rv), 16'hFF);
    #1 chk("R10 idle bus", 16'(rd_data), 16'h00);

    // R1 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re x", 16'(cur_x), 16'd0);
    chk("R1 re ctrl", 16'(ctrl_reg), 16'd0);
    chk("R1 re mode", 16'(mode_reg), 16'd0);
    rd(1'b0, 1'b0, rv); chk("R1 re A", 16'(rv), 16'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule